// File: doc/BRIEF.md
# Pulsed RF Vector Feedback Loop

This block closes a digital feedback loop around the drive of a pulsed superconducting cavity system. Each clock brings one signed 16-bit sample per cavity channel of a probe signal sitting at an intermediate frequency of exactly one quarter of the sample rate (10 MHz on a 40 MHz sample clock). At that ratio, four consecutive samples give +I, +Q, -I and -Q of the probe vector. The block therefore demodulates every channel with a two-bit phase counter and no multipliers. It sums the channel vectors into one controlled vector and compares that vector with an I/Q setpoint. It drives two signed 16-bit DAC words, I and Q, through a proportional-integral law.

The loop runs only while the pulse gate is high, which covers the long RF pulse of about 1.5 ms at a 5 Hz repetition rate. Outside the gate all loop state is cleared and the drive is zero, so every pulse starts from a fresh integrator. Each drive axis is limited to a programmed magnitude. A fault input, for example from quench diagnostics, silences the drive in the same cycle. It also sets a kill latch that keeps the drive off until an explicit clear pulse arrives.

Top module: `rfvc_loop_ctrl`

## Requirements
- R1: While reset is asserted and just after it is released, both DAC outputs are zero and the kill latch is clear.
- R2: While the loop runs, a two-bit phase counter starts at 0 and steps by one per clock. The sample taken at phase 0 becomes +I, phase 1 +Q, phase 2 -I and phase 3 -Q of its channel. The value -32768 negates to +32768 without overflow.
- R3: The controlled vector is the sum of the I parts and the sum of the Q parts over all NCH channels (1 to 8). The sum is registered one clock after demodulation.
- R4: Per axis, err = set - sum and integ = sat(integ + err) at each running clock. The drive is ((kp*err) >>> KSH) + (integ >>> ISH), where kp is signed and the updated integrator is used.
- R5: An ADC sample affects the DAC outputs after exactly three rising clock edges, well inside the 120-cycle budget.
- R6: The integrator saturates at its full signed IW-bit range and never wraps.
- R7: The drive word is saturated to the signed 16-bit range and then clamped per axis to ±mag_lim.
- R8: While pulse_gate is low, the phase counter, demodulated values, sums, integrators and outputs are all held at zero. Each new pulse therefore starts from a cleared integrator.
- R9: While fault_in is high, both DAC outputs are zero in the same cycle, with no clock edge needed.
- R10: A clock edge with fault_in high sets the kill latch. The latch keeps the outputs at zero and the loop cleared until a clock edge with kill_clr high and fault_in low. A clear pulse that arrives while fault_in is high has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pulse_gate | input | 1 | High during the RF pulse window |
| fault_in | input | 1 | Diagnostic fault, kills the drive |
| kill_clr | input | 1 | Clear pulse for the kill latch |
| adc_data | input | NCH*DW | Signed sample per channel, channel 0 in the low bits |
| set_i | input | DW+1+clog2(NCH) | Signed I setpoint |
| set_q | input | DW+1+clog2(NCH) | Signed Q setpoint |
| kp | input | KW | Signed proportional gain |
| mag_lim | input | DW-1 | Per-axis drive limit |
| dac_i | output | DW | Signed I drive word |
| dac_q | output | DW | Signed Q drive word |

## Verification
The loop is driven with several probe patterns:
- A rotating quadrature pattern with different vectors per channel shows whether the phase-to-destination and sign mapping is right.
- A constant value on all channels gives an alternating sum and exposes any mix-up between the I and Q paths.
- A single-sample impulse pins down the three-edge latency.
- A negative full-scale pattern checks negation at -32768.
- Extreme setpoints with zero proportional gain drive the integrator into saturation and then reverse it, which separates saturation from wrap.
- Small limits, pulse gaps, and fault and clear sequences in different orders test the clamp, the per-pulse restart and the kill latch.

// File: rtl/rfvc_pkg.sv
package rfvc_pkg;

   localparam int MAX_CH = 8;

   typedef enum logic [1:0] {
      PH_POS_I = 2'd0,
      PH_POS_Q = 2'd1,
      PH_NEG_I = 2'd2,
      PH_NEG_Q = 2'd3
   } rfvc_phase_e;

endpackage

// File: rtl/rfvc_iq_demod.sv
module rfvc_iq_demod #(
   parameter int DW = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 run,
   input  logic [1:0]           ph,
   input  logic [DW-1:0]        x,
   output logic signed [DW:0]   i_o,
   output logic signed [DW:0]   q_o
);
   import rfvc_pkg::*;

   logic signed [DW:0] x_ext;
   logic signed [DW:0] x_neg;

   assign x_ext = {x[DW-1], x};
   assign x_neg = -x_ext;

   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         i_o <= '0;
         q_o <= '0;
      end else begin
         case (rfvc_phase_e'(ph))
            PH_POS_I: i_o <= x_ext;
            PH_POS_Q: q_o <= x_ext;
            PH_NEG_I: i_o <= x_neg;
            PH_NEG_Q: q_o <= x_neg;
            default:  i_o <= x_ext;
         endcase
      end
   end

endmodule

// File: rtl/rfvc_vsum.sv
module rfvc_vsum #(
   parameter int NCH = 4,
   parameter int DW  = 16,
   parameter int SW  = DW + 1 + $clog2(NCH)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    run,
   input  logic [NCH*(DW+1)-1:0]   vec,
   output logic signed [SW-1:0]    sum_o
);
   logic signed [SW-1:0] acc;

   always_comb begin
      acc = '0;
      for (int k = 0; k < NCH; k++) begin
         acc = acc + SW'($signed(vec[k*(DW+1) +: (DW+1)]));
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !run) sum_o <= '0;
      else                sum_o <= acc;
   end

   a_r8_sum_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> sum_o == '0);

endmodule

// File: rtl/rfvc_pi_axis.sv
module rfvc_pi_axis #(
   parameter int SW  = 19,
   parameter int DW  = 16,
   parameter int KW  = 8,
   parameter int KSH = 4,
   parameter int IW  = 24,
   parameter int ISH = 6
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  run,
   input  logic signed [SW-1:0]  set_v,
   input  logic signed [SW-1:0]  fb_v,
   input  logic signed [KW-1:0]  kp,
   input  logic [DW-2:0]         lim,
   output logic signed [DW-1:0]  out_q
);
   localparam int EW = SW + 1;
   localparam int PW = EW + KW;
   localparam int CW = ((PW > IW) ? PW : IW) + 1;
   localparam longint IMAXL = (longint'(1) <<< (IW - 1)) - 1;
   localparam longint DMAXL = (longint'(1) <<< (DW - 1)) - 1;
   localparam logic signed [IW:0]   IMAX = (IW+1)'(IMAXL);
   localparam logic signed [IW:0]   IMIN = (IW+1)'(-IMAXL - 1);
   localparam logic signed [CW-1:0] DMAX = CW'(DMAXL);
   localparam logic signed [CW-1:0] DMIN = CW'(-DMAXL - 1);

   logic signed [EW-1:0]  err;
   logic signed [IW-1:0]  integ_q, integ_d;
   logic signed [IW:0]    isum;
   logic signed [PW-1:0]  prod, pterm;
   logic signed [CW-1:0]  comb_v, sat_v;
   logic signed [DW-1:0]  limp, limn, out_d;

   assign err   = EW'(set_v) - EW'(fb_v);
   assign isum  = (IW+1)'(integ_q) + (IW+1)'(err);
   assign prod  = err * kp;
   assign pterm = prod >>> KSH;
   assign limp  = $signed({1'b0, lim});
   assign limn  = -limp;

   always_comb begin
      if (isum > IMAX)      integ_d = IMAX[IW-1:0];
      else if (isum < IMIN) integ_d = IMIN[IW-1:0];
      else                  integ_d = isum[IW-1:0];

      comb_v = CW'(pterm) + CW'(integ_d >>> ISH);
      if (comb_v > DMAX)      sat_v = DMAX;
      else if (comb_v < DMIN) sat_v = DMIN;
      else                    sat_v = comb_v;

      if (sat_v[DW-1:0] > limp && sat_v >= 0)      out_d = limp;
      else if ($signed(sat_v[DW-1:0]) < limn)       out_d = limn;
      else                                          out_d = sat_v[DW-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         integ_q <= '0;
         out_q   <= '0;
      end else begin
         integ_q <= integ_d;
         out_q   <= out_d;
      end
   end

   a_r6_integ_rise: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !err[EW-1]) |=> integ_q >= $past(integ_q));
   a_r6_integ_fall: assert property (@(posedge clk) disable iff (!rst_n)
      (run && err[EW-1]) |=> integ_q <= $past(integ_q));
   a_r7_clamp: assert property (@(posedge clk) disable iff (!rst_n)
      run |=> (out_q <= $past(limp)) && (out_q >= -$past(limp)));
   a_r8_out_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (out_q == '0) && (integ_q == '0));

endmodule

// File: rtl/rfvc_loop_ctrl.sv
module rfvc_loop_ctrl #(
   parameter int NCH = 4,
   parameter int DW  = 16,
   parameter int KW  = 8,
   parameter int KSH = 4,
   parameter int IW  = 24,
   parameter int ISH = 6
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      pulse_gate,
   input  logic                      fault_in,
   input  logic                      kill_clr,
   input  logic [NCH*DW-1:0]         adc_data,
   input  logic [DW+$clog2(NCH):0]   set_i,
   input  logic [DW+$clog2(NCH):0]   set_q,
   input  logic [KW-1:0]             kp,
   input  logic [DW-2:0]             mag_lim,
   output logic [DW-1:0]             dac_i,
   output logic [DW-1:0]             dac_q
);
   localparam int SW = DW + 1 + $clog2(NCH);

   if (NCH < 1 || NCH > rfvc_pkg::MAX_CH) begin : g_bad_nch
      $error("NCH out of range");
   end
   if (IW < SW + 2 || IW > 62) begin : g_bad_iw
      $error("IW must cover the error width and fit 62 bits");
   end
   if (ISH >= IW || KSH >= SW + KW) begin : g_bad_shift
      $error("shift exceeds operand width");
   end

   logic                       kill_q;
   logic                       run;
   logic [1:0]                 ph_q;
   logic [NCH*(DW+1)-1:0]      i_vec, q_vec;
   logic signed [SW-1:0]       sum_ax [2];
   logic signed [SW-1:0]       set_ax [2];
   logic signed [DW-1:0]       out_ax [2];

   assign run       = pulse_gate & ~kill_q & ~fault_in;
   assign set_ax[0] = $signed(set_i);
   assign set_ax[1] = $signed(set_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         kill_q <= 1'b0;
         ph_q   <= 2'd0;
      end else begin
         kill_q <= fault_in | (kill_q & ~kill_clr);
         ph_q   <= run ? ph_q + 2'd1 : 2'd0;
      end
   end

   for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
      logic signed [DW:0] i_c, q_c;
      rfvc_iq_demod #(.DW(DW)) u_demod (
         .clk   (clk),
         .rst_n (rst_n),
         .run   (run),
         .ph    (ph_q),
         .x     (adc_data[ch*DW +: DW]),
         .i_o   (i_c),
         .q_o   (q_c)
      );
      assign i_vec[ch*(DW+1) +: (DW+1)] = i_c;
      assign q_vec[ch*(DW+1) +: (DW+1)] = q_c;
   end

   for (genvar ax = 0; ax < 2; ax++) begin : g_ax
      rfvc_vsum #(.NCH(NCH), .DW(DW), .SW(SW)) u_vsum (
         .clk   (clk),
         .rst_n (rst_n),
         .run   (run),
         .vec   ((ax == 0) ? i_vec : q_vec),
         .sum_o (sum_ax[ax])
      );
      rfvc_pi_axis #(.SW(SW), .DW(DW), .KW(KW), .KSH(KSH), .IW(IW), .ISH(ISH)) u_pi (
         .clk   (clk),
         .rst_n (rst_n),
         .run   (run),
         .set_v (set_ax[ax]),
         .fb_v  (sum_ax[ax]),
         .kp    ($signed(kp)),
         .lim   (mag_lim),
         .out_q (out_ax[ax])
      );
   end

   assign dac_i = (kill_q | fault_in) ? '0 : out_ax[0];
   assign dac_q = (kill_q | fault_in) ? '0 : out_ax[1];

   a_r2_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
      run |=> ph_q == $past(ph_q) + 2'd1);
   a_r8_phase_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !pulse_gate |=> ph_q == 2'd0);
   a_r10_fault_sets: assert property (@(posedge clk) disable iff (!rst_n)
      fault_in |=> kill_q);
   a_r10_kill_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (kill_q && !kill_clr) |=> kill_q);
   a_r9_fault_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      fault_in |-> (dac_i == '0) && (dac_q == '0));

endmodule

// File: tb/rfvc_loop_ctrl_bench.sv
module rfvc_loop_ctrl_bench;
   localparam int NCH = 4;
   localparam int DW  = 16;
   localparam int KW  = 8;
   localparam int KSH = 4;
   localparam int IW  = 24;
   localparam int ISH = 6;
   localparam int SW  = DW + 1 + $clog2(NCH);
   localparam longint IMAX = (longint'(1) <<< (IW - 1)) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pulse_gate = 1'b0, fault_in = 1'b0, kill_clr = 1'b0;
   logic [NCH*DW-1:0] adc_data = '0;
   logic [SW-1:0] set_i = '0, set_q = '0;
   logic [KW-1:0] kp = '0;
   logic [DW-2:0] mag_lim = '0;
   logic [DW-1:0] dac_i, dac_q;

   always #10 clk = ~clk;

   rfvc_loop_ctrl #(.NCH(NCH), .DW(DW), .KW(KW), .KSH(KSH), .IW(IW), .ISH(ISH)) u_rfvc_loop_ctrl (
      .clk(clk), .rst_n(rst_n), .pulse_gate(pulse_gate), .fault_in(fault_in),
      .kill_clr(kill_clr), .adc_data(adc_data), .set_i(set_i), .set_q(set_q),
      .kp(kp), .mag_lim(mag_lim), .dac_i(dac_i), .dac_q(dac_q)
   );

   int total = 0;
   int bad = 0;
   bit done = 0;

   int     b_adc [NCH];
   bit     b_gate, b_fault, b_clr;
   longint b_seti, b_setq;
   int     b_kp, b_lim;
   string  cur_tag;

   longint m_i [NCH];
   longint m_q [NCH];
   longint m_si, m_sq;
   longint m_int [2];
   longint m_out [2];
   int     m_ph;
   bit     m_kill;

   longint exp_iq[$];
   longint exp_qq[$];
   string  tag_q[$];

   task automatic check(string tag, longint act, longint exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
      end
   endtask

   // reference model of one rising edge, built from the requirements
   task automatic model_step();
      bit run;
      longint s, sv, e, itg, v, x;
      run = b_gate && !m_kill && !b_fault;
      for (int ax = 0; ax < 2; ax++) begin
         s  = (ax == 0) ? m_si : m_sq;
         sv = (ax == 0) ? b_seti : b_setq;
         e  = sv - s;
         if (run) begin
            itg = m_int[ax] + e;
            if (itg > IMAX) itg = IMAX;
            else if (itg < -IMAX - 1) itg = -IMAX - 1;
            v = ((longint'(b_kp) * e) >>> KSH) + (itg >>> ISH);
            if (v > 32767) v = 32767;
            else if (v < -32768) v = -32768;
            if (v > b_lim) v = b_lim;
            else if (v < -b_lim) v = -b_lim;
            m_int[ax] = itg;
            m_out[ax] = v;
         end else begin
            m_int[ax] = 0;
            m_out[ax] = 0;
         end
      end
      if (run) begin
         m_si = 0; m_sq = 0;
         for (int ch = 0; ch < NCH; ch++) begin
            m_si += m_i[ch];
            m_sq += m_q[ch];
         end
         for (int ch = 0; ch < NCH; ch++) begin
            x = b_adc[ch];
            case (m_ph)
               0: m_i[ch] = x;
               1: m_q[ch] = x;
               2: m_i[ch] = -x;
               default: m_q[ch] = -x;
            endcase
         end
         m_ph = (m_ph + 1) % 4;
      end else begin
         m_si = 0; m_sq = 0; m_ph = 0;
         for (int ch = 0; ch < NCH; ch++) begin
            m_i[ch] = 0; m_q[ch] = 0;
         end
      end
      m_kill = b_fault || (m_kill && !b_clr);
      exp_iq.push_back((m_kill || b_fault) ? 0 : m_out[0]);
      exp_qq.push_back((m_kill || b_fault) ? 0 : m_out[1]);
      tag_q.push_back(cur_tag);
   endtask

   // driver: apply inputs at the falling edge, push the expected result
   task automatic tick();
      @(negedge clk);
      pulse_gate = b_gate;
      fault_in   = b_fault;
      kill_clr   = b_clr;
      for (int ch = 0; ch < NCH; ch++) adc_data[ch*DW +: DW] = DW'(b_adc[ch]);
      set_i   = SW'(b_seti);
      set_q   = SW'(b_setq);
      kp      = KW'(b_kp);
      mag_lim = (DW-1)'(b_lim);
      model_step();
   endtask

   task automatic set_all(int v);
      for (int ch = 0; ch < NCH; ch++) b_adc[ch] = v;
   endtask

   task automatic idle(int n);
      b_gate = 0;
      set_all(0);
      for (int k = 0; k < n; k++) tick();
   endtask

   // monitor: compare after every rising edge
   initial begin
      longint ei, eq;
      string  t;
      forever begin
         @(posedge clk);
         #5;
         if (exp_iq.size() > 0) begin
            ei = exp_iq.pop_front();
            eq = exp_qq.pop_front();
            t  = tag_q.pop_front();
            check({t, " dac_i"}, longint'($signed(dac_i)), ei);
            check({t, " dac_q"}, longint'($signed(dac_q)), eq);
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog all requirements act=hung exp=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      b_gate = 0; b_fault = 0; b_clr = 0; b_seti = 0; b_setq = 0;
      b_kp = 0; b_lim = 32767; cur_tag = "R1";
      set_all(0);
      m_si = 0; m_sq = 0; m_ph = 0; m_kill = 0;
      for (int ax = 0; ax < 2; ax++) begin m_int[ax] = 0; m_out[ax] = 0; end
      for (int ch = 0; ch < NCH; ch++) begin m_i[ch] = 0; m_q[ch] = 0; end

      repeat (3) @(posedge clk);
      #5;
      check("R1 reset dac_i", longint'($signed(dac_i)), 0);
      check("R1 reset dac_q", longint'($signed(dac_q)), 0);
      @(negedge clk);
      rst_n = 1'b1;
      idle(2);

      // R2: rotating quadrature pattern, a different vector per channel
      cur_tag = "R2 quadrature";
      b_gate = 1; b_kp = 16; b_seti = 0; b_setq = 0; b_lim = 32767;
      for (int n = 0; n < 48; n++) begin
         for (int ch = 0; ch < NCH; ch++) begin
            case (n % 4)
               0: b_adc[ch] = 1000 * (ch + 1);
               1: b_adc[ch] = -500 * (ch + 1);
               2: b_adc[ch] = -1000 * (ch + 1);
               default: b_adc[ch] = 500 * (ch + 1);
            endcase
         end
         tick();
      end
      cur_tag = "R8 gap";
      idle(4);

      // R4: PI law with a setpoint and a mid-size gain
      cur_tag = "R4 pi";
      b_gate = 1; b_kp = 40; b_seti = 6000; b_setq = -2500;
      for (int n = 0; n < 60; n++) begin
         for (int ch = 0; ch < NCH; ch++) b_adc[ch] = (n % 2 == 0) ? 700 + 10 * ch : -300 * ch;
         tick();
      end
      idle(3);

      // R5: single sample impulse on channel 0
      cur_tag = "R5 latency";
      b_gate = 1; b_kp = 16; b_seti = 0; b_setq = 0;
      for (int n = 0; n < 12; n++) begin
         set_all(0);
         if (n == 0) b_adc[0] = 4000;
         tick();
      end
      idle(3);

      // R3: equal constant value on every channel, then distinct values
      cur_tag = "R3 dc";
      b_gate = 1; b_kp = -24; b_seti = 100; b_setq = 100;
      set_all(3000);
      for (int n = 0; n < 16; n++) tick();
      cur_tag = "R3 distinct";
      for (int n = 0; n < 16; n++) begin
         for (int ch = 0; ch < NCH; ch++) b_adc[ch] = (ch * 4111 + n * 977) % 20000 - 10000;
         tick();
      end
      idle(3);

      // R6: integrator driven to saturation, then reversed
      cur_tag = "R6 saturate";
      b_gate = 1; b_kp = 0; b_seti = 262143; b_setq = -262144; b_lim = 32767;
      set_all(0);
      for (int n = 0; n < 80; n++) tick();
      cur_tag = "R6 reverse";
      b_seti = -262144; b_setq = 262143;
      for (int n = 0; n < 80; n++) tick();
      idle(3);

      // R7: per-axis clamp, including a zero limit
      cur_tag = "R7 clamp";
      b_gate = 1; b_kp = 64; b_seti = 5000; b_setq = -5000; b_lim = 1000;
      for (int n = 0; n < 20; n++) tick();
      cur_tag = "R7 zero limit";
      b_lim = 0;
      for (int n = 0; n < 6; n++) tick();
      b_lim = 32767;
      idle(3);

      // R8: gate drop mid pulse, new pulse starts clean
      cur_tag = "R8 restart";
      b_gate = 1; b_kp = 8; b_seti = 20000; b_setq = 3000;
      set_all(250);
      for (int n = 0; n < 25; n++) tick();
      idle(2);
      b_gate = 1;
      set_all(250);
      for (int n = 0; n < 25; n++) tick();

      // R9: fault silences drive at once
      cur_tag = "R9 fault";
      b_fault = 1;
      tick();
      #1;
      check("R9 immediate dac_i", longint'($signed(dac_i)), 0);
      check("R9 immediate dac_q", longint'($signed(dac_q)), 0);
      for (int n = 0; n < 4; n++) tick();

      // R10: latch holds after fault drops; clear ignored while faulted
      cur_tag = "R10 hold";
      b_fault = 0;
      for (int n = 0; n < 5; n++) tick();
      cur_tag = "R10 clear during fault";
      b_fault = 1; b_clr = 1;
      tick();
      b_fault = 0; b_clr = 0;
      for (int n = 0; n < 4; n++) tick();
      cur_tag = "R10 clear";
      b_clr = 1;
      tick();
      b_clr = 0;
      for (int n = 0; n < 20; n++) tick();
      idle(3);

      // R2: negative full scale on every phase
      cur_tag = "R2 full scale";
      b_gate = 1; b_kp = 16; b_seti = 0; b_setq = 0;
      set_all(-32768);
      for (int n = 0; n < 16; n++) tick();
      idle(3);

      repeat (3) @(posedge clk);
      #6;
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule